// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Bus

This block is a target on an SMBus-style two-wire bus that fronts sixteen byte-wide configuration registers. It watches the open-drain clock and data lines, decodes the bus protocol, and returns its acknowledge and read data by pulling the data line low through `sda_oe`. Every register is always visible on a wide parallel output, so the logic around the block can use the settings directly.

A host writes by giving a starting index and then a byte count, followed by that many data bytes. The block stores them at consecutive indices. Any byte past the announced count is refused and is not stored. To read, the host gives the starting index in a short write, issues a repeated start and then the read address. The block first returns the value of the read-length register and then returns the register contents from the index upward. It keeps sending for as long as the host acknowledges. Both line inputs pass through a two-flop synchroniser and a glitch filter before the start, stop and clock edges are decoded.

The map holds three kinds of register. Writable registers can have some bits reserved. Two identity registers cannot be written. The read-length register at index 8 can be written. The register index is the low four bits of the index byte, and it wraps from 15 back to 0.

Top module: `cfgbus_slave`

## Requirements
- R1: The block acknowledges the address byte D2h (write) and D3h (read). It does not acknowledge any other address byte, and it then ignores every byte until the next start or stop.
- R2: In a write, the byte after the address is the starting index (its low 4 bits are used) and the next byte is the count X. The following X data bytes are stored at consecutive indices, each one acknowledged, and the index wraps from 15 to 0.
- R3: A data byte that arrives after X bytes have already been stored is not acknowledged and does not change any register.
- R4: In a read, the first byte after the D3h acknowledge is the value of register 8. The next bytes are the registers from the last index written, counting upward and wrapping. When the host does not acknowledge a byte, the block releases the data line and sends nothing more.
- R5: Register 8 resets to 08h and can be written with any value. A read then returns the written value as its first byte.
- R6: Register 7 reads 21h (revision 2 in bits 7:4, vendor 1 in bits 3:0) and register 9 reads 2Bh. Writes to either register are acknowledged and have no effect.
- R7: Reserved bits always read 0 and ignore writes. These are register 1 bits 3:2, register 5 bits 7, 5 and 4, and register 14 bit 7.
- R8: After reset, registers 0, 2 and 3 read FFh and register 1 reads F3h (all of its implemented bits set). All other writable registers read 00h.
- R9: A start or stop that arrives before all eight bits of a byte have been received throws that byte away and leaves the registers unchanged. After a start, the next byte is treated as an address.
- R10: The block changes the data-line drive and the register contents only while the clock line is low.
- R11: A low pulse on the clock line that lasts fewer than the filter length (3 system clocks) is ignored and does not disturb the byte being transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| reg_q | output | 128 | All registers; register i occupies bits 8i+7:8i |

## Verification
The cases hardest to reach from the ports are the aborted byte and the filtered glitch. Both need bus events placed in the middle of a byte, so a host that only moves whole bytes cannot produce them. The bench host therefore works at bit level. It shifts out a few bits of a data byte and then issues a stop, or a fresh start, while the clock is low. It also drops the clock line for a single system cycle inside a high phase. After each of these it reads all register values back at the parallel output.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned IDX_ID  = 7;
  localparam int unsigned IDX_CNT = 8;
  localparam int unsigned IDX_DEV = 9;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_TX,
    PH_SKIP
  } phase_t;

  // bits that a bus write may change
  function automatic logic [BYTE_W-1:0] field_mask(input int unsigned i);
    case (i)
      1:              field_mask = 8'hF3;
      5:              field_mask = 8'h4F;
      IDX_ID, IDX_DEV: field_mask = 8'h00;
      14:             field_mask = 8'h7F;
      default:        field_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_init(input int unsigned i,
                                                   input logic [BYTE_W-1:0] id_byte,
                                                   input logic [BYTE_W-1:0] dev_byte,
                                                   input logic [BYTE_W-1:0] cnt_byte);
    case (i)
      0, 2, 3: field_init = 8'hFF;
      1:       field_init = 8'hF3;
      IDX_ID:  field_init = id_byte;
      IDX_CNT: field_init = cnt_byte;
      IDX_DEV: field_init = dev_byte;
      default: field_init = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgbus_deglitch.sv
module cfgbus_deglitch #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [1:0]    meta;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 2'b11;
      dout <= 1'b1;
      run  <= '0;
    end else begin
      meta <= {meta[0], din};
      if (meta[1] == dout) begin
        run <= '0;
      end else if (run == CW'(FILT_CYC - 1)) begin
        dout <= meta[1];
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgbus_events.sv
module cfgbus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
  import cfgbus_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter logic [7:0]  ID_BYTE   = 8'h21,
  parameter logic [7:0]  DEV_ID    = 8'h2B,
  parameter logic [7:0]  CNT_RESET = 8'h08,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [IW-1:0]              rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [BYTE_W-1:0]          cnt_byte,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] arr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] MASK = field_mask(g);
    localparam logic [BYTE_W-1:0] INIT = field_init(g, ID_BYTE, DEV_ID, CNT_RESET);
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= INIT;
      end else if (wr_en && wr_idx == IW'(g)) begin
        q <= (wr_data & MASK) | (INIT & ~MASK);
      end
    end

    assign arr[g] = q;
    assign regs_flat[g*BYTE_W +: BYTE_W] = q;
  end

  assign rd_data  = arr[rd_idx];
  assign cnt_byte = arr[IDX_CNT];
endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
#(
  parameter int unsigned IW    = 4,
  parameter logic [6:0]  ADDR7 = 7'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_c,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] cnt_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IW-1:0]     rd_idx
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  phase_t            phase;
  logic [3:0]        bitn;
  logic              in_ack, host_ack, send_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr, left, tx_next;
  logic [IW-1:0]     idx;

  assign rd_idx  = idx;
  assign tx_next = send_cnt ? cnt_byte : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitn     <= '0;
      in_ack   <= 1'b0;
      host_ack <= 1'b0;
      send_cnt <= 1'b0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      left     <= '0;
      idx      <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_c) begin
        phase  <= PH_IDLE;
        bitn   <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        phase  <= PH_ADDR;
        bitn   <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (in_ack) begin
            if (phase == PH_TX && !send_cnt) host_ack <= ~sda_c;
          end else if (bitn < LAST_BIT) begin
            rx_sr <= {rx_sr[BYTE_W-2:0], sda_c};
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            bitn  <= bitn + 1'b1;
          end
        end else if (scl_fall) begin
          if (!in_ack && bitn == LAST_BIT) begin
            // whole byte seen: decide the acknowledge and act on it
            in_ack <= 1'b1;
            sda_oe <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (rx_sr[7:1] == ADDR7) begin
                  sda_oe <= 1'b1;
                  if (rx_sr[0]) begin
                    phase    <= PH_TX;
                    send_cnt <= 1'b1;
                    host_ack <= 1'b1;
                  end else begin
                    phase <= PH_INDEX;
                  end
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_INDEX: begin
                idx    <= rx_sr[IW-1:0];
                sda_oe <= 1'b1;
                phase  <= PH_COUNT;
              end
              PH_COUNT: begin
                left   <= rx_sr;
                sda_oe <= 1'b1;
                phase  <= PH_WDATA;
              end
              PH_WDATA: begin
                if (left != '0) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= idx;
                  wr_data <= rx_sr;
                  idx     <= idx + 1'b1;
                  left    <= left - 1'b1;
                  sda_oe  <= 1'b1;
                end
              end
              default: ;
            endcase
          end else if (in_ack) begin
            // acknowledge slot over: release, maybe start the next byte out
            in_ack <= 1'b0;
            bitn   <= '0;
            sda_oe <= 1'b0;
            if (phase == PH_TX) begin
              if (host_ack) begin
                tx_sr    <= tx_next;
                sda_oe   <= ~tx_next[7];
                send_cnt <= 1'b0;
                if (!send_cnt) idx <= idx + 1'b1;
              end else begin
                phase <= PH_SKIP;
              end
            end
          end else if (phase == PH_TX) begin
            sda_oe <= ~tx_sr[7];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter logic [6:0]  ADDR7     = 7'h69,
  parameter logic [3:0]  REV_ID    = 4'h2,
  parameter logic [3:0]  VEND_ID   = 4'h1,
  parameter logic [7:0]  DEV_ID    = 8'h2B,
  parameter logic [7:0]  CNT_RESET = 8'h08,
  parameter int unsigned FILT_CYC  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] reg_q
);
  localparam int unsigned IW      = $clog2(NUM_REGS);
  localparam logic [7:0]  ID_BYTE = {REV_ID, VEND_ID};

  logic              scl_c, sda_c;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic              wr_en;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data, cnt_byte;

  cfgbus_deglitch #(.FILT_CYC(FILT_CYC)) u_scl_flt (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_c)
  );

  cfgbus_deglitch #(.FILT_CYC(FILT_CYC)) u_sda_flt (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_c)
  );

  cfgbus_events u_events (
    .clk(clk), .rst(rst), .scl(scl_c), .sda(sda_c),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  cfgbus_engine #(.IW(IW), .ADDR7(ADDR7)) u_engine (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_c(sda_c),
    .rd_data(rd_data), .cnt_byte(cnt_byte),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx)
  );

  cfgbus_regbank #(
    .NUM_REGS(NUM_REGS), .ID_BYTE(ID_BYTE),
    .DEV_ID(DEV_ID), .CNT_RESET(CNT_RESET)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt_byte(cnt_byte),
    .regs_flat(reg_q)
  );
endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk
  import cfgbus_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter logic [7:0]  ID_BYTE   = 8'h21,
  parameter logic [7:0]  DEV_ID    = 8'h2B,
  parameter logic [7:0]  CNT_RESET = 8'h08
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_i,
  input logic                       sda_oe,
  input logic [NUM_REGS*BYTE_W-1:0] reg_q
);
  logic [NUM_REGS*BYTE_W-1:0] reg_d;
  logic [NUM_REGS-1:0]        chg;

  always_ff @(posedge clk) reg_d <= reg_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    localparam logic [BYTE_W-1:0] KEEP0 = ~field_mask(g) & ~field_init(g, ID_BYTE, DEV_ID, CNT_RESET);
    assign chg[g] = reg_q[g*BYTE_W +: BYTE_W] != reg_d[g*BYTE_W +: BYTE_W];

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (reg_q[g*BYTE_W +: BYTE_W] & KEEP0) == '0);
  end

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_reg_change_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (chg != '0) |-> !scl_i);

  assert_one_reg_per_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot0(chg));

  assert_id_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(reg_q[IDX_ID*BYTE_W +: BYTE_W]) &&
                     $stable(reg_q[IDX_DEV*BYTE_W +: BYTE_W])));
endmodule

bind cfgbus_slave cfgbus_slave_chk #(
  .NUM_REGS(NUM_REGS), .ID_BYTE({REV_ID, VEND_ID}),
  .DEV_ID(DEV_ID), .CNT_RESET(CNT_RESET)
) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .reg_q(reg_q)
);

// File: tb/cfgbus_slave_tb_top.sv
module cfgbus_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 16;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_drv = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] reg_q;
  logic sda_line;

  assign sda_line = !(sda_drv || sda_oe);
  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbus_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  int checks = 0;
  int fails  = 0;
  int viol   = 0;
  logic [7:0] model [NR];
  logic [7:0] exp_q [$];
  string      req_q [$];
  logic [7:0] obs_q [$];

  function automatic logic [7:0] bmask(int i);
    case (i)
      1: return 8'hF3;
      5: return 8'h4F;
      7, 9: return 8'h00;
      14: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] binit(int i);
    case (i)
      0, 2, 3: return 8'hFF;
      1: return 8'hF3;
      7: return 8'h21;
      8: return 8'h08;
      9: return 8'h2B;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qtick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b0; qtick();
    scl = 1'b1; qtick();
    sda_drv = 1'b1; qtick();
    scl = 1'b0; qtick();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b1; qtick();
    scl = 1'b1; qtick();
    sda_drv = 1'b0; qtick();
  endtask

  task automatic put_bit(logic b, bit glitch);
    sda_drv = !b; qtick();
    scl = 1'b1; qtick();
    if (glitch) begin
      scl = 1'b0; @(negedge clk);
      scl = 1'b1;
    end
    qtick();
    scl = 1'b0; qtick();
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b0; qtick();
    scl = 1'b1; qtick();
    b = sda_line; qtick();
    scl = 1'b0; qtick();
  endtask

  task automatic put_byte(logic [7:0] d, bit glitch, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(bit ack_it);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    obs_q.push_back(d);
    put_bit(!ack_it, 1'b0);
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < NR; i++) check(req, reg_q[i*8 +: 8], model[i]);
  endtask

  task automatic do_write(logic [7:0] n, logic [7:0] x, logic [7:0] d[$], bit glitch, string req);
    logic a;
    bus_start();
    put_byte(8'hD2, 1'b0, a); check("R1 write address ack", a, 1);
    put_byte(n, 1'b0, a);     check({req, " index ack"}, a, 1);
    put_byte(x, 1'b0, a);     check({req, " count ack"}, a, 1);
    for (int k = 0; k < d.size(); k++) begin
      int j;
      put_byte(d[k], glitch, a);
      check((k < x) ? {req, " data ack"} : "R3 extra byte nack", a, (k < x) ? 1 : 0);
      if (k < x) begin
        j = (n + k) % NR;
        model[j] = (d[k] & bmask(j)) | (binit(j) & ~bmask(j));
      end
    end
    bus_stop();
    qtick();
    check_regs(req);
  endtask

  task automatic do_read(logic [7:0] n, int nbytes, string req);
    logic a;
    bus_start();
    put_byte(8'hD2, 1'b0, a); check("R1 write address ack", a, 1);
    put_byte(n, 1'b0, a);     check({req, " index ack"}, a, 1);
    bus_start();
    put_byte(8'hD3, 1'b0, a); check("R1 read address ack", a, 1);
    exp_q.push_back(model[8]); req_q.push_back("R5 count byte first");
    get_byte(nbytes > 0);
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(model[(n + k) % NR]); req_q.push_back({req, " data byte"});
      get_byte(k < nbytes - 1);
    end
    repeat (4) @(negedge clk);
    check("R4 released after nack", sda_oe, 0);
    bus_stop();
    qtick();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected byte", obs_q.pop_front(), 8'hxx);
        end else begin
          check(req_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
        end
      end
    end
  end

  // R10 bench-side observation
  initial begin
    logic po;
    logic [NR*8-1:0] pr;
    @(negedge clk);
    while (rst) @(negedge clk);
    po = sda_oe; pr = reg_q;
    forever begin
      @(negedge clk);
      if (scl && (sda_oe && !po || reg_q != pr)) viol++;
      po = sda_oe; pr = reg_q;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    for (int i = 0; i < NR; i++) model[i] = binit(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 reset idle no drive", sda_oe, 0);
    check_regs("R8 R5 R6 reset values");

    do_write(8'h00, 8'd3, '{8'hA5, 8'h5A, 8'h3C}, 1'b0, "R2 R7 write from 0");
    do_write(8'hFE, 8'd3, '{8'h91, 8'h22, 8'h33}, 1'b0, "R2 wrap write");
    do_write(8'h04, 8'd1, '{8'h77, 8'h88}, 1'b0, "R3 count limit");
    do_write(8'h05, 8'd1, '{8'hFF}, 1'b0, "R7 reserved bits");
    do_write(8'h07, 8'd3, '{8'hFF, 8'h04, 8'hFF}, 1'b0, "R6 R5 identity and count");
    do_read(8'h0D, 4, "R4 read wrap");

    // R1 foreign address
    bus_start();
    put_byte(8'hA0, 1'b0, a); check("R1 foreign address nack", a, 0);
    put_byte(8'h00, 1'b0, a); check("R1 ignored after nack", a, 0);
    bus_stop(); qtick();
    check_regs("R1 no change");

    // R9 stop in mid byte
    bus_start();
    put_byte(8'hD2, 1'b0, a); put_byte(8'h03, 1'b0, a); put_byte(8'h02, 1'b0, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    bus_stop(); qtick();
    check_regs("R9 stop abort");

    // R9 start in mid byte, then a fresh transfer
    bus_start();
    put_byte(8'hD2, 1'b0, a); put_byte(8'h04, 1'b0, a); put_byte(8'h01, 1'b0, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1, 1'b0);
    check_regs("R9 partial byte not stored");
    do_write(8'h04, 8'd1, '{8'h5C}, 1'b0, "R9 restart write");

    do_write(8'h0A, 8'd1, '{8'h96}, 1'b1, "R11 glitch rejected");
    do_write(8'h08, 8'd1, '{8'h02}, 1'b0, "R5 count rewrite");
    do_read(8'h0F, 2, "R5 R4 short read");

    repeat (20) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    check("R10 no change while SCL high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule